// File: doc/BRIEF.md
# Dual-Channel Serial Converter Input Register

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host writes it over a three-wire serial link: a serial clock, a serial data line and an active-low frame sync. Each frame carries one 16-bit word, most significant bit first. The block samples data on falling edges of the serial clock. One bit of the word chooses the channel, and the low twelve bits are the code. A completed word is written into that channel's input latch.

An active-low load input sets when the converter registers take the latched codes. Held low, it gives automatic mode: the addressed channel's converter register takes the new code as soon as the 16th falling edge of the frame has been seen. Held high, words only stage codes in the input latches. A later falling transition of the load input then moves both latches into both converter registers in the same system clock cycle. The serial pins and the load pin are asynchronous to the system clock. They are resynchronised, and serial clock edges are found by oversampling. The serial clock must therefore run well below the system clock. The link has no stream handshake and so no back-pressure: the host may send at any time, and every frame it sends is taken. The outputs are the two converter register values and a one-cycle update strobe for each channel.

Top module: `dacin_front`

## Requirements
- R1: After reset both converter registers and both input latches read zero, and no update strobe is raised until an update occurs.
- R2: A frame is the run of falling serial clock edges while sync_n is low. Data is sampled on each falling edge, most significant bit first, and word bits 11..0 form the 12-bit code.
- R3: Word bit 12 picks the channel (0 = channel A, 1 = channel B). Word bits 15..13 have no effect on any output.
- R4: With load_n low, a completed 16-bit frame writes its code into the addressed channel's converter register and leaves the other channel unchanged.
- R5: With load_n high, a completed frame changes no converter register and raises no update strobe. It only stages the code in the addressed input latch.
- R6: A high-to-low transition of load_n copies both input latches into both converter registers. Both update strobes are raised in the same cycle.
- R7: A frame in which sync_n returns high before the 16th falling edge is discarded and writes no input latch.
- R8: Falling serial clock edges while sync_n is high are ignored. Falling edges after the 16th in one frame are ignored.
- R9: An update strobe is high for exactly one system clock per converter register update, in the same cycle the new value first appears on the output. A converter register never changes without its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| sync_n | input | 1 | Active-low frame sync |
| load_n | input | 1 | Active-low load: low level gives automatic update, falling transition gives simultaneous update |
| dac_a | output | 12 | Channel A converter register |
| dac_b | output | 12 | Channel B converter register |
| upd_a | output | 1 | One-cycle strobe when dac_a is loaded |
| upd_b | output | 1 | One-cycle strobe when dac_b is loaded |

## Verification
The bench sends words whose unused top bits are all ones. A design that decoded the wrong bit as the channel would then steer codes to the wrong output. It cuts frames short after 1 to 15 edges and then forces a load transition, so a design that kept a partial word would show it in the converter registers. It also clocks the serial line while sync is high and runs frames past 16 edges. A design that counted those edges would shift the code or write a garbled word. In staged mode it counts strobes and records the cycle of each one. This exposes a design that updates a register early, updates the channels in different cycles, or stretches a strobe over several cycles.

// File: rtl/dacin_pkg.sv
package dacin_pkg;
  localparam int NCH = 2;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/dacin_sync.sv
// Multi-stage resynchroniser for a vector of asynchronous inputs.
module dacin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacin_shift.sv
// Frame capture: counts falling serial clock edges inside a frame and
// keeps only the trailing bits that carry the channel select and code.
module dacin_shift #(
  parameter int WORD_BITS = 16,
  parameter int SEL_BIT = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_s,
  input  logic           sdata_s,
  input  logic           sync_n_s,
  output logic           word_vld,
  output logic [SEL_BIT:0] word_low
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);

  logic             sclk_q;
  logic             fall;
  logic [CNT_W-1:0] cnt;
  logic [SEL_BIT:0] sh;

  assign fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      word_vld <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      word_vld <= 1'b0;
      if (sync_n_s) begin
        cnt <= '0;
        sh  <= '0;
      end else if (fall && cnt != FULL) begin
        sh  <= {sh[SEL_BIT-1:0], sdata_s};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) word_vld <= 1'b1;
      end
    end
  end

  assign word_low = sh;
endmodule

// File: rtl/dacin_load.sv
// Load pin decode: level selects automatic mode, falling edge triggers
// a simultaneous transfer of all channels.
module dacin_load (
  input  logic clk,
  input  logic rst_n,
  input  logic load_s,
  output logic auto_en,
  output logic xfer_all
);
  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_s;
  end

  assign auto_en  = ~load_s;
  assign xfer_all = load_q & ~load_s;
endmodule

// File: rtl/dacin_chan.sv
// One channel: input latch, converter register and update strobe.
module dacin_chan #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] code,
  input  logic              auto_en,
  input  logic              xfer_all,
  output logic [DATA_W-1:0] dac,
  output logic              upd
);
  logic [DATA_W-1:0] lat;
  logic              ev;

  assign ev = (wr & auto_en) | xfer_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
      dac <= '0;
      upd <= 1'b0;
    end else begin
      if (wr) lat <= code;
      if (ev) dac <= wr ? code : lat;
      upd <= ev;
    end
  end
endmodule

// File: rtl/dacin_front.sv
module dacin_front #(
  parameter int DATA_W = 12,
  parameter int WORD_BITS = 16,
  parameter int SEL_BIT = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sync_n,
  input  logic              load_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              upd_a,
  output logic              upd_b
);
  import dacin_pkg::*;

  localparam int PINS = 4;
  localparam logic [PINS-1:0] PIN_RST = 4'b0101;

  logic [PINS-1:0]    pins_s;
  logic               sclk_s, sdata_s, sync_n_s, load_s;
  logic               word_vld;
  logic [SEL_BIT:0]   word_low;
  logic               auto_en, xfer_all;
  logic [DATA_W-1:0]  dac_v [NCH];
  logic [NCH-1:0]     upd_v;
  chan_e              sel;

  dacin_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({load_n, sync_n, sdata, sclk}),
    .q(pins_s)
  );

  assign sclk_s   = pins_s[0];
  assign sdata_s  = pins_s[1];
  assign sync_n_s = pins_s[2];
  assign load_s   = pins_s[3];

  dacin_shift #(.WORD_BITS(WORD_BITS), .SEL_BIT(SEL_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sdata_s(sdata_s), .sync_n_s(sync_n_s),
    .word_vld(word_vld), .word_low(word_low)
  );

  dacin_load u_load (
    .clk(clk), .rst_n(rst_n), .load_s(load_s),
    .auto_en(auto_en), .xfer_all(xfer_all)
  );

  assign sel = chan_e'(word_low[SEL_BIT]);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic wr_c;
      assign wr_c = word_vld & (sel == chan_e'(c));
      dacin_chan #(.DATA_W(DATA_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_c), .code(word_low[DATA_W-1:0]),
        .auto_en(auto_en), .xfer_all(xfer_all),
        .dac(dac_v[c]), .upd(upd_v[c])
      );
    end
  endgenerate

  assign dac_a = dac_v[CH_A];
  assign dac_b = dac_v[CH_B];
  assign upd_a = upd_v[CH_A];
  assign upd_b = upd_v[CH_B];
endmodule

// File: rtl/dacin_front_chk.sv
module dacin_front_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_s,
  input logic              word_vld,
  input logic              word_sel,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              upd_a,
  input logic              upd_b
);
  a_r9_a_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_a != $past(dac_a)) |-> upd_a);
  a_r9_b_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_b != $past(dac_b)) |-> upd_b);
  a_r5_staged_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && load_s) |=> !(upd_a || upd_b));
  a_r6_both_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_s) |=> (upd_a && upd_b));
  a_r4_auto_a: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !load_s && !word_sel) |=> upd_a);
  a_r4_auto_b: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !load_s && word_sel) |=> upd_b);
  a_r3_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !load_s && !$fell(load_s) && word_sel) |=> !upd_a);
endmodule

bind dacin_front dacin_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_s(load_s),
  .word_vld(word_vld), .word_sel(word_low[SEL_BIT]),
  .dac_a(dac_a), .dac_b(dac_b), .upd_a(upd_a), .upd_b(upd_b)
);

// File: tb/dacin_front_tb.sv
module dacin_front_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sclk, sdata, sync_n, load_n;
  logic [11:0] dac_a, dac_b;
  logic upd_a, upd_b;

  dacin_front u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
    .sync_n(sync_n), .load_n(load_n),
    .dac_a(dac_a), .dac_b(dac_b), .upd_a(upd_a), .upd_b(upd_b)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, pa = 0, pb = 0, ca = 0, cb = 0;
  bit done = 0;
  logic [11:0] m_lat [2];
  logic [11:0] m_dac [2];

  always @(negedge clk) begin
    cyc++;
    if (upd_a) begin pa++; ca = cyc; end
    if (upd_b) begin pb++; cb = cyc; end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req, int exp_pa, int exp_pb);
    chk(dac_a == m_dac[0], req, "dac_a", dac_a, m_dac[0]);
    chk(dac_b == m_dac[1], req, "dac_b", dac_b, m_dac[1]);
    chk(pa == exp_pa, req, "strobe count A (R9)", pa, exp_pa);
    chk(pb == exp_pb, req, "strobe count B (R9)", pb, exp_pb);
  endtask

  task automatic clr();
    @(negedge clk);
    pa = 0; pb = 0;
  endtask

  task automatic ser_bit(bit b);
    @(negedge clk) sdata = b;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
  endtask

  task automatic send(logic [15:0] w, int nedges);
    @(negedge clk) sync_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nedges; i++)
      ser_bit(i < 16 ? w[15-i] : bit'($urandom % 2));
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // Full frame model; returns expected strobe counts.
  task automatic full_frame(logic [15:0] w, string req);
    int ch;
    int ea, eb;
    ch = int'(w[12]);
    clr();
    send(w, 16);
    m_lat[ch] = w[11:0];
    ea = 0; eb = 0;
    if (!load_n) begin
      m_dac[ch] = w[11:0];
      if (ch == 0) ea = 1; else eb = 1;
    end
    check_state(req, ea, eb);
  endtask

  task automatic set_load(bit v, string req);
    bit falling;
    falling = load_n && !v;
    clr();
    load_n = v;
    repeat (10) @(negedge clk);
    if (falling) begin
      m_dac[0] = m_lat[0];
      m_dac[1] = m_lat[1];
      check_state(req, 1, 1);
      chk(ca == cb, "R6", "strobe cycle A vs B", ca, cb);
    end else begin
      check_state(req, 0, 0);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    sclk = 1'b1; sdata = 1'b0; sync_n = 1'b1; load_n = 1'b0; rst_n = 1'b0;
    m_lat[0] = '0; m_lat[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check_state("R1", 0, 0);

    // R1: latches cleared, observed through a load transition
    set_load(1'b1, "R1");
    set_load(1'b0, "R1");

    // R2/R4: automatic update of channel A
    full_frame(16'h0ABC, "R2 R4");
    // R3: top bits all ones, bit 12 selects channel B
    full_frame(16'hF123, "R3");
    full_frame(16'hE456, "R3");

    // R5: staging with load high
    set_load(1'b1, "R5");
    full_frame(16'h0555, "R5");
    full_frame(16'h1AAA, "R5");
    // R6: simultaneous transfer
    set_load(1'b0, "R6");

    // R7: short frames discarded, observed through a transfer
    set_load(1'b1, "R7");
    clr(); send(16'h0777, 10); check_state("R7", 0, 0);
    clr(); send(16'h1321, 15); check_state("R7", 0, 0);
    set_load(1'b0, "R7");
    clr(); send(16'h0999, 1); check_state("R7", 0, 0);

    // R8: edges with sync high are ignored
    clr();
    for (int i = 0; i < 16; i++) ser_bit(bit'(i % 2));
    repeat (12) @(negedge clk);
    check_state("R8", 0, 0);
    // R8: edges beyond 16 are ignored
    full_frame_extra: begin
      clr();
      send(16'h1234, 21);
      m_lat[1] = 12'h234; m_dac[1] = 12'h234;
      check_state("R8", 0, 1);
    end

    // Random mix
    for (int it = 0; it < 50; it++) begin
      int r;
      logic [15:0] w;
      r = int'($urandom % 8);
      w = 16'($urandom);
      if (r == 0) begin
        clr(); send(w, 1 + int'($urandom % 15)); check_state("R7", 0, 0);
      end else if (r == 1) begin
        set_load(~load_n, load_n ? "R6" : "R5");
      end else begin
        full_frame(w, load_n ? "R5" : "R4");
      end
    end
    set_load(1'b1, "R5");
    set_load(1'b0, "R6");

    finish_up();
  end
endmodule